// File: doc/BRIEF.md
# Atomic Memory Operation Unit

This block executes the atomic instructions of a single-hart 32-bit core: load-reserved, store-conditional and the nine read-modify-write atomics. The core hands it one decoded request at a time: an operation code, a byte address, a source operand and a destination tag. The unit then drives a single-ported word memory directly and returns the destination value together with a one-cycle completion pulse. The memory answers a read on the clock edge after the read is issued.

The unit holds one reservation, which is a valid flag and a word address. A load-reserved sets it. It is dropped by any store-conditional, by any write to the reserved word (an atomic write from this unit, or a plain store that the core reports on the snoop inputs), by the clear input, and by reset. An atomic read-modify-write occupies the memory port for two back-to-back cycles: a read, then a write of the computed word to the same address. The value returned to the core is the word as it was before the write.

A four-state machine does the sequencing. The states are IDLE, READ, WRITE and DONE, with these transitions:

- IDLE to READ accepts a load-reserved or an atomic.
- IDLE to WRITE accepts a store-conditional that holds the reservation.
- IDLE to DONE accepts a failing store-conditional or an unlisted code.
- READ to DONE ends a load-reserved.
- READ to WRITE continues an atomic.
- WRITE to DONE follows every write.
- DONE to IDLE is unconditional.

Top module: `amo_unit`

## Requirements
- R1: A load-reserved (code 0) reads the addressed word, returns it as the result, and leaves the reservation valid on that word.
- R2: A store-conditional (code 1) whose word address equals the valid reservation writes the source operand to that word with exactly one memory write, and returns 0.
- R3: A write to the reserved word clears the reservation, so that a later store-conditional to that word fails. This applies to a plain store reported on the snoop inputs and to an atomic write from this unit. A write to any other word leaves the reservation intact.
- R4: Reset and the clear input each invalidate the reservation. When a clear and a set fall in the same cycle, the clear wins.
- R5: A store-conditional that does not hold the reservation returns 1 and makes no memory access. Every store-conditional, whether it succeeds or fails, leaves no reservation behind.
- R6: An atomic read-modify-write issues one read and then, in the very next cycle, one write to the same word, with no other access in between. It returns the word read, not the word written.
- R7: The atomics swap (2), add modulo 2^32 (3), xor (4), and (5) and or (6) write the source, the sum, or the bitwise result of the old word and the source.
- R8: Minimum (7) and maximum (8) compare as two's complement numbers. Unsigned minimum (9) and unsigned maximum (10) compare as magnitudes. Each writes the selected operand.
- R9: The latency, counted in clock edges from the accepting edge to the edge that raises done, is 1 for a failing store-conditional or an unlisted code (11 to 15), 2 for a load-reserved or a successful store-conditional, and 3 for an atomic. An unlisted code returns 0 and makes no memory access.
- R10: done is high for exactly one cycle. result and done_tag (which echoes the request tag) are valid in that same cycle. req_ready is high only in IDLE, and the memory port is idle while req_ready is high.
- R11: The two low address bits are ignored. Requests and snooped stores are matched on the word address alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request accepted this cycle |
| req_op | input | 4 | Operation code |
| req_addr | input | ADDR_W | Byte address of the request |
| req_src | input | XLEN | Source operand |
| req_tag | input | TAG_W | Destination tag |
| st_valid | input | 1 | A plain store is being performed by the core |
| st_addr | input | ADDR_W | Byte address of that plain store |
| resv_clear | input | 1 | Invalidate the reservation |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W-2 | Memory word address |
| mem_wdata | output | XLEN | Memory write data |
| mem_rdata | input | XLEN | Memory read data, valid the cycle after a read |
| done | output | 1 | Completion pulse |
| done_tag | output | TAG_W | Tag of the completed request |
| result | output | XLEN | Value for the destination register |

## Verification
The assertions take the following for granted:

- The memory returns the addressed word on the edge after a read and keeps that value until the next read.
- The core raises req_valid only when req_ready is high.
- The core never reports a plain store in the same cycle as one of this unit's own memory accesses.

The bench meets these conditions in three ways. Its memory model registers read data only on read cycles. It drives a request once per call and holds nothing else pending. It pulses the snoop and clear inputs only while the unit is idle, between requests.

// File: rtl/amo_pkg.sv
package amo_pkg;

    typedef enum logic [3:0] {
        OP_LR   = 4'd0,
        OP_SC   = 4'd1,
        OP_SWAP = 4'd2,
        OP_ADD  = 4'd3,
        OP_XOR  = 4'd4,
        OP_AND  = 4'd5,
        OP_OR   = 4'd6,
        OP_MIN  = 4'd7,
        OP_MAX  = 4'd8,
        OP_MINU = 4'd9,
        OP_MAXU = 4'd10
    } amo_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DONE  = 2'd3
    } amo_state_e;

    // True for the read-modify-write group (swap through unsigned max)
    function automatic logic is_rmw(input logic [3:0] code);
        return (code >= OP_SWAP) && (code <= OP_MAXU);
    endfunction

endpackage

// File: rtl/amo_alu.sv
module amo_alu
    import amo_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [3:0]      op,
    input  logic [XLEN-1:0] old_val,
    input  logic [XLEN-1:0] src_val,
    output logic [XLEN-1:0] new_val
);

    logic lt_signed;
    logic lt_unsigned;

    always_comb begin
        lt_signed   = $signed(old_val) < $signed(src_val);
        lt_unsigned = old_val < src_val;
    end

    always_comb begin
        unique case (op)
            OP_SWAP: new_val = src_val;
            OP_ADD:  new_val = old_val + src_val;
            OP_XOR:  new_val = old_val ^ src_val;
            OP_AND:  new_val = old_val & src_val;
            OP_OR:   new_val = old_val | src_val;
            OP_MIN:  new_val = lt_signed   ? old_val : src_val;
            OP_MAX:  new_val = lt_signed   ? src_val : old_val;
            OP_MINU: new_val = lt_unsigned ? old_val : src_val;
            OP_MAXU: new_val = lt_unsigned ? src_val : old_val;
            default: new_val = src_val;
        endcase
    end

endmodule

// File: rtl/amo_resv.sv
module amo_resv #(
    parameter int WADDR_W = 30
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_en,
    input  logic [WADDR_W-1:0] set_waddr,
    input  logic               sc_en,
    input  logic               clr,
    input  logic               snoop_en,
    input  logic [WADDR_W-1:0] snoop_waddr,
    input  logic               wr_en,
    input  logic [WADDR_W-1:0] wr_waddr,
    input  logic [WADDR_W-1:0] query_waddr,
    output logic               query_hit,
    output logic               valid_o,
    output logic [WADDR_W-1:0] waddr_o
);

    logic               valid_q;
    logic [WADDR_W-1:0] waddr_q;
    logic               kill;

    always_comb begin
        kill = clr || sc_en
            || (snoop_en && valid_q && (snoop_waddr == waddr_q))
            || (wr_en    && valid_q && (wr_waddr    == waddr_q));
        query_hit = valid_q && (query_waddr == waddr_q);
    end

    // Any invalidation takes priority over a new reservation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            waddr_q <= '0;
        end else if (kill) begin
            valid_q <= 1'b0;
        end else if (set_en) begin
            valid_q <= 1'b1;
            waddr_q <= set_waddr;
        end
    end

    assign valid_o = valid_q;
    assign waddr_o = waddr_q;

endmodule

// File: rtl/amo_seq.sv
module amo_seq
    import amo_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int WADDR_W = 30,
    parameter int TAG_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [3:0]         req_op,
    input  logic [WADDR_W-1:0] req_waddr,
    input  logic [XLEN-1:0]    req_src,
    input  logic [TAG_W-1:0]   req_tag,
    output logic               req_ready,
    input  logic               resv_hit,
    output logic               resv_set,
    output logic               resv_sc,
    output logic [3:0]         op_q,
    output logic [XLEN-1:0]    src_q,
    input  logic [XLEN-1:0]    alu_val,
    output logic               mem_en,
    output logic               mem_we,
    output logic [WADDR_W-1:0] mem_addr,
    output logic [XLEN-1:0]    mem_wdata,
    input  logic [XLEN-1:0]    mem_rdata,
    output logic               done,
    output logic [TAG_W-1:0]   done_tag,
    output logic [XLEN-1:0]    result
);

    amo_state_e         state_q, state_d;
    logic [WADDR_W-1:0] waddr_q;
    logic [TAG_W-1:0]   tag_q;
    logic [XLEN-1:0]    res_q;
    logic               accept;

    assign accept = req_valid && (state_q == ST_IDLE);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (req_op == OP_LR || is_rmw(req_op))
                        state_d = ST_READ;
                    else if (req_op == OP_SC && resv_hit)
                        state_d = ST_WRITE;
                    else
                        state_d = ST_DONE;
                end
            end
            ST_READ:  state_d = (op_q == OP_LR) ? ST_DONE : ST_WRITE;
            ST_WRITE: state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Request capture and result holding
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= '0;
            waddr_q <= '0;
            src_q   <= '0;
            tag_q   <= '0;
            res_q   <= '0;
        end else begin
            if (accept) begin
                op_q    <= req_op;
                waddr_q <= req_waddr;
                src_q   <= req_src;
                tag_q   <= req_tag;
                if (req_op == OP_SC)
                    res_q <= resv_hit ? XLEN'(0) : XLEN'(1);
                else
                    res_q <= '0;
            end
            if (state_q == ST_WRITE && is_rmw(op_q))
                res_q <= mem_rdata;
        end
    end

    // Outputs
    always_comb begin
        req_ready = 1'b0;
        resv_set  = 1'b0;
        resv_sc   = 1'b0;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        done      = 1'b0;
        done_tag  = '0;
        result    = '0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                resv_sc   = accept && (req_op == OP_SC);
            end
            ST_READ: begin
                mem_en   = 1'b1;
                mem_addr = waddr_q;
                resv_set = (op_q == OP_LR);
            end
            ST_WRITE: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = waddr_q;
                mem_wdata = (op_q == OP_SC) ? src_q : alu_val;
            end
            ST_DONE: begin
                done     = 1'b1;
                done_tag = tag_q;
                result   = (op_q == OP_LR) ? mem_rdata : res_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/amo_unit.sv
module amo_unit
    import amo_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [3:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [XLEN-1:0]   req_src,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic              resv_clear,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-3:0] mem_addr,
    output logic [XLEN-1:0]   mem_wdata,
    input  logic [XLEN-1:0]   mem_rdata,
    output logic              done,
    output logic [TAG_W-1:0]  done_tag,
    output logic [XLEN-1:0]   result
);

    localparam int WADDR_W = ADDR_W - 2;

    logic [WADDR_W-1:0] req_waddr;
    logic [WADDR_W-1:0] st_waddr;
    logic               unused_lo;
    logic               resv_hit;
    logic               resv_set;
    logic               resv_sc;
    logic               resv_valid;
    logic [WADDR_W-1:0] resv_waddr;
    logic [3:0]         op_q;
    logic [XLEN-1:0]    src_q;
    logic [XLEN-1:0]    alu_val;

    assign req_waddr = req_addr[ADDR_W-1:2];
    assign st_waddr  = st_addr[ADDR_W-1:2];
    assign unused_lo = ^{req_addr[1:0], st_addr[1:0]};

    amo_seq #(
        .XLEN    (XLEN),
        .WADDR_W (WADDR_W),
        .TAG_W   (TAG_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_waddr (req_waddr),
        .req_src   (req_src),
        .req_tag   (req_tag),
        .req_ready (req_ready),
        .resv_hit  (resv_hit),
        .resv_set  (resv_set),
        .resv_sc   (resv_sc),
        .op_q      (op_q),
        .src_q     (src_q),
        .alu_val   (alu_val),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .done      (done),
        .done_tag  (done_tag),
        .result    (result)
    );

    amo_alu #(
        .XLEN (XLEN)
    ) u_alu (
        .op      (op_q),
        .old_val (mem_rdata),
        .src_val (src_q),
        .new_val (alu_val)
    );

    amo_resv #(
        .WADDR_W (WADDR_W)
    ) u_resv (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_en      (resv_set),
        .set_waddr   (mem_addr),
        .sc_en       (resv_sc),
        .clr         (resv_clear),
        .snoop_en    (st_valid),
        .snoop_waddr (st_waddr),
        .wr_en       (mem_en && mem_we),
        .wr_waddr    (mem_addr),
        .query_waddr (req_waddr),
        .query_hit   (resv_hit),
        .valid_o     (resv_valid),
        .waddr_o     (resv_waddr)
    );

endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk #(
    parameter int XLEN   = 32,
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              st_valid,
    input logic [ADDR_W-1:0] st_addr,
    input logic              resv_clear,
    input logic              mem_en,
    input logic              mem_we,
    input logic [ADDR_W-3:0] mem_addr,
    input logic [XLEN-1:0]   mem_rdata,
    input logic              done,
    input logic [XLEN-1:0]   result,
    input logic              resv_valid,
    input logic [ADDR_W-3:0] resv_waddr
);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready); // R10

    AST_IDLE_PORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_en); // R10

    AST_RMW_SAME_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we && $past(mem_en && !mem_we)) |-> (mem_addr == $past(mem_addr))); // R6

    AST_RMW_OLD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we && $past(mem_en && !mem_we)) |=> (done && result == $past(mem_rdata))); // R6

    AST_SNOOP_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && resv_valid && st_addr[ADDR_W-1:2] == resv_waddr) |=> !resv_valid); // R3

    AST_OWN_WRITE_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we && resv_valid && mem_addr == resv_waddr) |=> !resv_valid); // R3

    AST_CLEAR_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
        resv_clear |=> !resv_valid); // R4

endmodule

bind amo_unit amo_unit_chk #(
    .XLEN   (XLEN),
    .ADDR_W (ADDR_W),
    .TAG_W  (TAG_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .st_valid   (st_valid),
    .st_addr    (st_addr),
    .resv_clear (resv_clear),
    .mem_en     (mem_en),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_rdata  (mem_rdata),
    .done       (done),
    .result     (result),
    .resv_valid (resv_valid),
    .resv_waddr (resv_waddr)
);

// File: tb/amo_unit_tb.sv
module amo_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_op = '0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_src = '0;
    logic [4:0]  req_tag = '0;
    logic        st_valid = 1'b0;
    logic [31:0] st_addr = '0;
    logic        resv_clear = 1'b0;
    logic        mem_en;
    logic        mem_we;
    logic [29:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        done;
    logic [4:0]  done_tag;
    logic [31:0] result;

    logic [31:0] mem [16];
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    int          n_cmp = 0;
    int          n_bad = 0;

    always #10 clk = ~clk;

    amo_unit u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_op     (req_op),
        .req_addr   (req_addr),
        .req_src    (req_src),
        .req_tag    (req_tag),
        .st_valid   (st_valid),
        .st_addr    (st_addr),
        .resv_clear (resv_clear),
        .mem_en     (mem_en),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .done       (done),
        .done_tag   (done_tag),
        .result     (result)
    );

    // Word memory with one cycle of read latency
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                mem[mem_addr[3:0]] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                mem_rdata <= mem[mem_addr[3:0]];
                rd_cnt <= rd_cnt + 1;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [3:0] op, input logic [31:0] addr, input logic [31:0] src,
                          input logic [4:0] tag, output logic [31:0] res, output int lat,
                          output logic [4:0] rtag, output int nrd, output int nwr);
        int rd0;
        int wr0;
        @(negedge clk);
        rd0 = rd_cnt;
        wr0 = wr_cnt;
        req_valid = 1'b1;
        req_op = op;
        req_addr = addr;
        req_src = src;
        req_tag = tag;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R10: actual no done expected done within 20 cycles");
        end
        res = result;
        rtag = done_tag;
        nrd = rd_cnt - rd0;
        nwr = wr_cnt - wr0;
    endtask

    task automatic pulse_store(input logic [31:0] addr);
        @(negedge clk);
        st_valid = 1'b1;
        st_addr = addr;
        @(negedge clk);
        st_valid = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        resv_clear = 1'b1;
        @(negedge clk);
        resv_clear = 1'b0;
    endtask

    function automatic logic [31:0] pick(input int i);
        case (i)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'h7FFF_FFFF;
            3: return 32'h8000_0000;
            4: return 32'hFFFF_FFFF;
            5: return 32'h1234_5678;
            6: return 32'hFFFF_0000;
            default: return 32'h0000_0005;
        endcase
    endfunction

    function automatic logic [31:0] model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
        case (op)
            4'd2: return b;
            4'd3: return a + b;
            4'd4: return a ^ b;
            4'd5: return a & b;
            4'd6: return a | b;
            4'd7: return ($signed(a) < $signed(b)) ? a : b;
            4'd8: return ($signed(a) < $signed(b)) ? b : a;
            4'd9: return (a < b) ? a : b;
            default: return (a < b) ? b : a;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] res;
        logic [4:0]  rt;
        int          lat;
        int          nrd;
        int          nwr;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk("R10 ready after reset", {31'd0, req_ready}, 32'd1);
        chk("R10 done after reset", {31'd0, done}, 32'd0);
        chk("R10 port idle after reset", {31'd0, mem_en}, 32'd0);

        // R4 no reservation after reset: SC fails silently (R5, R9)
        run_op(4'd1, 32'h10, 32'hAAAA_AAAA, 5'd3, res, lat, rt, nrd, nwr);
        chk("R4 SC after reset fails", res, 32'd1);
        chk("R5 failed SC no access", nrd + nwr, 0);
        chk("R9 failed SC latency", lat, 1);
        chk("R10 tag echo", {27'd0, rt}, {27'd0, 5'd3});

        // Preload words 0..15 by swap
        for (int w = 0; w < 16; w++) begin
            run_op(4'd2, w * 4, 32'h100 + w, 5'd0, res, lat, rt, nrd, nwr);
        end

        // R1 load-reserved then R2 successful SC
        run_op(4'd0, 32'h14, 32'd0, 5'd7, res, lat, rt, nrd, nwr);
        chk("R1 LR value", res, 32'h105);
        chk("R9 LR latency", lat, 2);
        chk("R10 LR tag", {27'd0, rt}, {27'd0, 5'd7});
        run_op(4'd1, 32'h14, 32'hCAFE_0001, 5'd8, res, lat, rt, nrd, nwr);
        chk("R2 SC success code", res, 32'd0);
        chk("R2 SC memory", mem[5], 32'hCAFE_0001);
        chk("R2 SC single write", nwr * 16 + nrd, 16);
        chk("R9 SC success latency", lat, 2);
        // R5 reservation consumed by the SC
        run_op(4'd1, 32'h14, 32'hDEAD_0000, 5'd9, res, lat, rt, nrd, nwr);
        chk("R5 second SC fails", res, 32'd1);
        chk("R5 memory untouched", mem[5], 32'hCAFE_0001);

        // R3 snooped store to the reserved word
        run_op(4'd0, 32'h18, 32'd0, 5'd1, res, lat, rt, nrd, nwr);
        pulse_store(32'h1A);
        run_op(4'd1, 32'h18, 32'h1111_1111, 5'd1, res, lat, rt, nrd, nwr);
        chk("R3 snoop kills reservation", res, 32'd1);
        chk("R3 no write after kill", nwr, 0);

        // R3 snooped store to another word leaves it
        run_op(4'd0, 32'h18, 32'd0, 5'd1, res, lat, rt, nrd, nwr);
        pulse_store(32'h1C);
        run_op(4'd1, 32'h18, 32'h2222_2222, 5'd1, res, lat, rt, nrd, nwr);
        chk("R3 other-word store keeps reservation", res, 32'd0);
        chk("R3 SC wrote", mem[6], 32'h2222_2222);

        // R3 atomic write to the reserved word
        run_op(4'd0, 32'h20, 32'd0, 5'd1, res, lat, rt, nrd, nwr);
        run_op(4'd3, 32'h20, 32'd1, 5'd1, res, lat, rt, nrd, nwr);
        run_op(4'd1, 32'h20, 32'h3333_3333, 5'd1, res, lat, rt, nrd, nwr);
        chk("R3 AMO kills reservation", res, 32'd1);
        chk("R3 AMO-updated word kept", mem[8], 32'h109);

        // R3 atomic to another word keeps it
        run_op(4'd0, 32'h20, 32'd0, 5'd1, res, lat, rt, nrd, nwr);
        run_op(4'd3, 32'h24, 32'd1, 5'd1, res, lat, rt, nrd, nwr);
        run_op(4'd1, 32'h20, 32'h4444_4444, 5'd1, res, lat, rt, nrd, nwr);
        chk("R3 AMO elsewhere keeps reservation", res, 32'd0);

        // R4 clear input
        run_op(4'd0, 32'h28, 32'd0, 5'd1, res, lat, rt, nrd, nwr);
        pulse_clear();
        run_op(4'd1, 32'h28, 32'h5555_5555, 5'd1, res, lat, rt, nrd, nwr);
        chk("R4 clear kills reservation", res, 32'd1);
        chk("R4 memory untouched", mem[10], 32'h10A);

        // R5 SC to another word fails and consumes the reservation
        run_op(4'd0, 32'h2C, 32'd0, 5'd1, res, lat, rt, nrd, nwr);
        run_op(4'd1, 32'h30, 32'h6666_6666, 5'd1, res, lat, rt, nrd, nwr);
        chk("R5 mismatched SC fails", res, 32'd1);
        run_op(4'd1, 32'h2C, 32'h6666_6666, 5'd1, res, lat, rt, nrd, nwr);
        chk("R5 failed SC still clears", res, 32'd1);

        // R11 low address bits ignored
        run_op(4'd0, 32'h37, 32'd0, 5'd1, res, lat, rt, nrd, nwr);
        chk("R11 LR with low bits", res, 32'h10D);
        run_op(4'd1, 32'h35, 32'h7777_7777, 5'd1, res, lat, rt, nrd, nwr);
        chk("R11 SC with other low bits", res, 32'd0);
        chk("R11 word written", mem[13], 32'h7777_7777);

        // R9 unlisted code
        run_op(4'd12, 32'h04, 32'hFFFF_FFFF, 5'd30, res, lat, rt, nrd, nwr);
        chk("R9 unlisted result", res, 32'd0);
        chk("R9 unlisted latency", lat, 1);
        chk("R9 unlisted no access", nrd + nwr, 0);
        chk("R10 unlisted tag", {27'd0, rt}, {27'd0, 5'd30});

        // R6 R7 R8 sweep: every atomic over all operand pairs
        for (int op = 2; op <= 10; op++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    int w;
                    logic [31:0] a;
                    logic [31:0] b;
                    w = (i * 8 + j + op) % 16;
                    a = pick(i);
                    b = pick(j);
                    run_op(4'd2, w * 4, a, 5'd0, res, lat, rt, nrd, nwr);
                    run_op(4'(op), w * 4 + j % 4, b, 5'(op + i), res, lat, rt, nrd, nwr);
                    chk((op >= 7) ? "R8 old value returned" : "R7 old value returned", res, a);
                    chk((op >= 7) ? "R8 stored value" : "R7 stored value", mem[w], model(4'(op), a, b));
                    chk("R6 one read one write", nrd * 16 + nwr, 17);
                    chk("R9 atomic latency", lat, 3);
                    chk("R10 atomic tag", {27'd0, rt}, {27'd0, 5'(op + i)});
                end
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule